// File: doc/BRIEF.md
# Twin-Port Synchronous Word Store

This block is a memory of 4K or 8K words by 18 bits with two ports, left and right, that work independently. Each port has its own clock. At the rising edge of its clock a port captures its address, write data, read/write strobe, chip enables and lane selects. Both ports may reach any word at any time.

A static mode pin on each port sets the read latency. In flow-through mode the word appears in the cycle that follows the capturing edge. In pipelined mode an extra output register adds one more cycle. The outputs are a data bus plus a drive-enable vector with one bit per 9-bit lane, in place of real three-state pins. A lane is driven only when three things hold together: the port is selected for a read, that lane is requested, and the asynchronous output enable is low.

If both ports write the same word at a shared edge, the result is defined. The left port wins every lane that both ports write, and a clash flag pulses for one cycle. The mode, chip-enable and lane pins are plain control pins and have no handshake.

Top module: `twin_port_sram`

## Requirements
- R1: A port is selected only when its `ce0_*_n` is low and its `ce1_*` is high at the same rising edge. Any other combination makes that cycle a no-op: nothing is written and no lane is driven.
- R2: The word has two lanes. Lane 0 is bits 8:0 and is selected by `lane_*_n[0]`; lane 1 is bits 17:9 and is selected by `lane_*_n[1]`. A select is active low. A write changes only the selected lanes.
- R3: `rw_*_n` low at the edge means write and high means read. All inputs except output enable are captured at the rising edge of the port's clock.
- R4: With `pipe_*` low (flow-through), a read captured at edge E is driven on `rdata_*`/`drive_*` from E until the next edge. A write cycle drives no lane.
- R5: With `pipe_*` high (pipelined), the output state in the cycle after edge E+1 comes from the controls captured at E. Deselection, and the return to driving, both take effect one edge later than in flow-through mode.
- R6: `drive_*[i]` is high only for a selected read with lane i selected and `oe_*_n` low. Output enable acts at once, with no clock edge.
- R7: A read captured at the same edge as a write to the same word returns the old contents. A read captured at any later edge returns the new contents.
- R8: When both ports write the same word at a shared edge, each lane that both write takes the left data, and a lane that only the right port writes takes the right data. `clash` is high for the one cycle after the next edge.
- R9: A word written through one port can be read through the other port.
- R10: While `rst_n` is low, and after it, no lane is driven and `clash` is low until a read or a clash occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| clk_r | input | 1 | Right port clock |
| rst_n | input | 1 | Active-low synchronous reset, seen by both domains |
| pipe_l | input | 1 | Left read path: 0 flow-through, 1 pipelined |
| ce0_l_n | input | 1 | Left enable, active low |
| ce1_l | input | 1 | Left enable, active high |
| rw_l_n | input | 1 | Left strobe: 0 write, 1 read |
| lane_l_n | input | 2 | Left lane selects, active low |
| addr_l | input | ADDR_W | Left word address |
| wdata_l | input | 18 | Left write data |
| oe_l_n | input | 1 | Left output enable, asynchronous, active low |
| rdata_l | output | 18 | Left read data |
| drive_l | output | 2 | Left per-lane drive enable |
| pipe_r | input | 1 | Right read path: 0 flow-through, 1 pipelined |
| ce0_r_n | input | 1 | Right enable, active low |
| ce1_r | input | 1 | Right enable, active high |
| rw_r_n | input | 1 | Right strobe: 0 write, 1 read |
| lane_r_n | input | 2 | Right lane selects, active low |
| addr_r | input | ADDR_W | Right word address |
| wdata_r | input | 18 | Right write data |
| oe_r_n | input | 1 | Right output enable, asynchronous, active low |
| rdata_r | output | 18 | Right read data |
| drive_r | output | 2 | Right per-lane drive enable |
| clash | output | 1 | One-cycle pulse for a same-word, same-lane double write |

## Verification
The properties assume that the mode pins stay fixed while out of reset. They also assume that all synchronous inputs are stable around each rising edge. The same-word precedence and the clash pulse are checked only for ports whose clocks share edges. The stimulus runs both ports from one clock, with the left port in flow-through mode and the right port pipelined. Every input changes on the falling edge, so the edges on which the precedence rule depends always coincide.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic {
    RD_FLOW = 1'b0,
    RD_PIPE = 1'b1
  } rd_path_e;
endpackage

// File: rtl/tps_port.sv
module tps_port
  import tps_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pipe_mode,
  input  logic                      ce0_n,
  input  logic                      ce1,
  input  logic                      rw_n,
  input  logic [LANES-1:0]          lane_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      oe_n,
  input  logic [LANES*LANE_W-1:0]   rword,
  output logic                      cmd_wr,
  output logic [LANES-1:0]          cmd_lanes,
  output logic [ADDR_W-1:0]         cmd_addr,
  output logic [LANES*LANE_W-1:0]   cmd_data,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic [LANES-1:0]          drive
);
  localparam int WORD_W = LANES * LANE_W;

  logic               sel_q, wr_q, prd_q;
  logic [LANES-1:0]   lane_q, plane_q;
  logic [WORD_W-1:0]  pdata_q;
  logic               rd_now, rd_out;
  logic [LANES-1:0]   lane_out;
  rd_path_e           path;

  assign path = rd_path_e'(pipe_mode);

  // input capture: the select decode is registered with the rest
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      wr_q   <= 1'b0;
      lane_q <= '0;
    end else begin
      sel_q  <= ~ce0_n & ce1;
      wr_q   <= ~ce0_n & ce1 & ~rw_n;
      lane_q <= ~lane_n;
    end
  end

  always_ff @(posedge clk) begin
    cmd_addr <= addr;
    cmd_data <= wdata;
  end

  assign rd_now    = sel_q & ~wr_q;
  assign cmd_wr    = wr_q;
  assign cmd_lanes = lane_q;

  // optional output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_q   <= 1'b0;
      plane_q <= '0;
    end else begin
      prd_q   <= rd_now;
      plane_q <= lane_q;
    end
  end

  always_ff @(posedge clk) pdata_q <= rword;

  always_comb begin
    if (path == RD_PIPE) begin
      rd_out   = prd_q;
      lane_out = plane_q;
      rdata    = pdata_q;
    end else begin
      rd_out   = rd_now;
      lane_out = lane_q;
      rdata    = rword;
    end
    drive = {LANES{rd_out & ~oe_n}} & lane_out;
  end
endmodule

// File: rtl/tps_store.sv
module tps_store #(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk_l,
  input  logic                      clk_r,
  input  logic                      rst_n,
  input  logic                      wr_l,
  input  logic [LANES-1:0]          lanes_l,
  input  logic [ADDR_W-1:0]         addr_l,
  input  logic [LANES*LANE_W-1:0]   data_l,
  input  logic                      wr_r,
  input  logic [LANES-1:0]          lanes_r,
  input  logic [ADDR_W-1:0]         addr_r,
  input  logic [LANES*LANE_W-1:0]   data_r,
  output logic [LANES*LANE_W-1:0]   word_l,
  output logic [LANES*LANE_W-1:0]   word_r,
  output logic                      clash
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES-1:0] hit;
  logic             same_addr;

  assign same_addr = (addr_l == addr_r);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank_l [DEPTH];
    logic [LANE_W-1:0] bank_r [DEPTH];
    logic              live_l [DEPTH];
    logic              live_r [DEPTH];
    logic              put_l, put_r;

    assign hit[g] = wr_l & lanes_l[g] & wr_r & lanes_r[g] & same_addr;
    assign put_l  = wr_l & lanes_l[g];
    assign put_r  = wr_r & lanes_r[g] & ~hit[g];

    always_ff @(posedge clk_l)
      if (put_l) bank_l[addr_l] <= data_l[g*LANE_W +: LANE_W];

    always_ff @(posedge clk_r)
      if (put_r) bank_r[addr_r] <= data_r[g*LANE_W +: LANE_W];

    // live-value bits: xor of the pair selects the bank holding the latest lane
    always_ff @(posedge clk_l) begin
      if (!rst_n) begin
        for (int k = 0; k < DEPTH; k++) live_l[k] <= 1'b0;
      end else if (put_l) begin
        live_l[addr_l] <= live_r[addr_l];
      end
    end

    always_ff @(posedge clk_r) begin
      if (!rst_n) begin
        for (int k = 0; k < DEPTH; k++) live_r[k] <= 1'b0;
      end else if (put_r) begin
        live_r[addr_r] <= ~live_l[addr_r];
      end
    end

    assign word_l[g*LANE_W +: LANE_W] =
      (live_l[addr_l] ^ live_r[addr_l]) ? bank_r[addr_l] : bank_l[addr_l];
    assign word_r[g*LANE_W +: LANE_W] =
      (live_l[addr_r] ^ live_r[addr_r]) ? bank_r[addr_r] : bank_l[addr_r];
  end

  always_ff @(posedge clk_r) begin
    if (!rst_n) clash <= 1'b0;
    else        clash <= |hit;
  end
endmodule

// File: rtl/twin_port_sram.sv
module twin_port_sram #(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk_l,
  input  logic                      clk_r,
  input  logic                      rst_n,
  input  logic                      pipe_l,
  input  logic                      ce0_l_n,
  input  logic                      ce1_l,
  input  logic                      rw_l_n,
  input  logic [LANES-1:0]          lane_l_n,
  input  logic [ADDR_W-1:0]         addr_l,
  input  logic [LANES*LANE_W-1:0]   wdata_l,
  input  logic                      oe_l_n,
  output logic [LANES*LANE_W-1:0]   rdata_l,
  output logic [LANES-1:0]          drive_l,
  input  logic                      pipe_r,
  input  logic                      ce0_r_n,
  input  logic                      ce1_r,
  input  logic                      rw_r_n,
  input  logic [LANES-1:0]          lane_r_n,
  input  logic [ADDR_W-1:0]         addr_r,
  input  logic [LANES*LANE_W-1:0]   wdata_r,
  input  logic                      oe_r_n,
  output logic [LANES*LANE_W-1:0]   rdata_r,
  output logic [LANES-1:0]          drive_r,
  output logic                      clash
);
  localparam int WORD_W = LANES * LANE_W;

  logic              wr_l, wr_r;
  logic [LANES-1:0]  lanes_l, lanes_r;
  logic [ADDR_W-1:0] caddr_l, caddr_r;
  logic [WORD_W-1:0] cdata_l, cdata_r, word_l, word_r;

  tps_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_left (
    .clk(clk_l), .rst_n(rst_n), .pipe_mode(pipe_l), .ce0_n(ce0_l_n), .ce1(ce1_l),
    .rw_n(rw_l_n), .lane_n(lane_l_n), .addr(addr_l), .wdata(wdata_l), .oe_n(oe_l_n),
    .rword(word_l), .cmd_wr(wr_l), .cmd_lanes(lanes_l), .cmd_addr(caddr_l),
    .cmd_data(cdata_l), .rdata(rdata_l), .drive(drive_l)
  );

  tps_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_right (
    .clk(clk_r), .rst_n(rst_n), .pipe_mode(pipe_r), .ce0_n(ce0_r_n), .ce1(ce1_r),
    .rw_n(rw_r_n), .lane_n(lane_r_n), .addr(addr_r), .wdata(wdata_r), .oe_n(oe_r_n),
    .rword(word_r), .cmd_wr(wr_r), .cmd_lanes(lanes_r), .cmd_addr(caddr_r),
    .cmd_data(cdata_r), .rdata(rdata_r), .drive(drive_r)
  );

  tps_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
    .clk_l(clk_l), .clk_r(clk_r), .rst_n(rst_n),
    .wr_l(wr_l), .lanes_l(lanes_l), .addr_l(caddr_l), .data_l(cdata_l),
    .wr_r(wr_r), .lanes_r(lanes_r), .addr_r(caddr_r), .data_r(cdata_r),
    .word_l(word_l), .word_r(word_r), .clash(clash)
  );
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int ADDR_W = 12,
  parameter int LANES  = 2
) (
  input logic              clk_l,
  input logic              clk_r,
  input logic              rst_n,
  input logic              pipe_l,
  input logic              ce0_l_n,
  input logic              ce1_l,
  input logic              rw_l_n,
  input logic [LANES-1:0]  lane_l_n,
  input logic [ADDR_W-1:0] addr_l,
  input logic              oe_l_n,
  input logic [LANES-1:0]  drive_l,
  input logic              pipe_r,
  input logic              ce0_r_n,
  input logic              ce1_r,
  input logic              rw_r_n,
  input logic [ADDR_W-1:0] addr_r,
  input logic              oe_r_n,
  input logic [LANES-1:0]  drive_r,
  input logic              clash
);
  // R1: a deselected flow-through cycle drives nothing after its edge
  a_r1_deselect_quiet: assert property (@(posedge clk_l) disable iff (!rst_n)
    (!pipe_l && !(!ce0_l_n && ce1_l)) |=> (drive_l == '0));

  // R2: flow-through drive never covers a lane that was not selected
  a_r2_lane_subset: assert property (@(posedge clk_l) disable iff (!rst_n)
    !pipe_l |-> ((drive_l & $past(lane_l_n)) == '0));

  // R4: a flow-through write cycle drives no lane
  a_r4_write_no_drive: assert property (@(posedge clk_l) disable iff (!rst_n)
    (!pipe_l && !ce0_l_n && ce1_l && !rw_l_n) |=> (drive_l == '0));

  // R5: pipelined deselection shows up one edge later
  a_r5_pipe_deselect: assert property (@(posedge clk_r) disable iff (!rst_n)
    (pipe_r && !(!ce0_r_n && ce1_r)) |=> ##1 (drive_r == '0));

  // R6: output enable high blocks every lane on both ports
  a_r6_oe_left: assert property (@(posedge clk_l) disable iff (!rst_n)
    oe_l_n |-> (drive_l == '0));
  a_r6_oe_right: assert property (@(posedge clk_r) disable iff (!rst_n)
    oe_r_n |-> (drive_r == '0));

  // R8: a clash pulse needs two selected writes to one word two edges back
  a_r8_clash_cause: assert property (@(posedge clk_r) disable iff (!rst_n)
    clash |-> $past(!ce0_l_n && ce1_l && !rw_l_n && !ce0_r_n && ce1_r && !rw_r_n
                    && (addr_l == addr_r), 2));
endmodule

bind twin_port_sram tps_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk_l(clk_l), .clk_r(clk_r), .rst_n(rst_n), .pipe_l(pipe_l),
  .ce0_l_n(ce0_l_n), .ce1_l(ce1_l), .rw_l_n(rw_l_n), .lane_l_n(lane_l_n),
  .addr_l(addr_l), .oe_l_n(oe_l_n), .drive_l(drive_l), .pipe_r(pipe_r),
  .ce0_r_n(ce0_r_n), .ce1_r(ce1_r), .rw_r_n(rw_r_n), .addr_r(addr_r),
  .oe_r_n(oe_r_n), .drive_r(drive_r), .clash(clash)
);

// File: tb/twin_port_sram_test.sv
module twin_port_sram_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        pipe_l, ce0_l_n, ce1_l, rw_l_n, oe_l_n;
  logic [1:0]  lane_l_n, drive_l;
  logic [11:0] addr_l;
  logic [17:0] wdata_l, rdata_l;
  logic        pipe_r, ce0_r_n, ce1_r, rw_r_n, oe_r_n;
  logic [1:0]  lane_r_n, drive_r;
  logic [11:0] addr_r;
  logic [17:0] wdata_r, rdata_r;
  logic        clash;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  twin_port_sram uut (
    .clk_l(clk), .clk_r(clk), .rst_n(rst_n),
    .pipe_l(pipe_l), .ce0_l_n(ce0_l_n), .ce1_l(ce1_l), .rw_l_n(rw_l_n),
    .lane_l_n(lane_l_n), .addr_l(addr_l), .wdata_l(wdata_l), .oe_l_n(oe_l_n),
    .rdata_l(rdata_l), .drive_l(drive_l),
    .pipe_r(pipe_r), .ce0_r_n(ce0_r_n), .ce1_r(ce1_r), .rw_r_n(rw_r_n),
    .lane_r_n(lane_r_n), .addr_r(addr_r), .wdata_r(wdata_r), .oe_r_n(oe_r_n),
    .rdata_r(rdata_r), .drive_r(drive_r), .clash(clash)
  );

  // entry: port(1, 0=left) wr(1) lane_n(2) addr(12) data(18) expect(18)
  localparam logic [51:0] VECS [0:7] = '{
    {1'b0, 1'b1, 2'b00, 12'h010, 9'h155, 9'h0AA, 18'h0},
    {1'b1, 1'b0, 2'b00, 12'h010, 18'h0, 9'h155, 9'h0AA},
    {1'b1, 1'b1, 2'b01, 12'h010, 9'h1F0, 9'h111, 18'h0},
    {1'b0, 1'b0, 2'b00, 12'h010, 18'h0, 9'h1F0, 9'h0AA},
    {1'b0, 1'b1, 2'b10, 12'h123, 9'h000, 9'h033, 18'h0},
    {1'b0, 1'b1, 2'b01, 12'h123, 9'h0CC, 9'h1FF, 18'h0},
    {1'b1, 1'b0, 2'b00, 12'h123, 18'h0, 9'h0CC, 9'h033},
    {1'b0, 1'b0, 2'b00, 12'h123, 18'h0, 9'h0CC, 9'h033}
  };

  task automatic check(input bit ok, input string tag, input logic [17:0] act,
                       input logic [17:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_l();
    ce0_l_n = 1'b1; ce1_l = 1'b0; rw_l_n = 1'b1; lane_l_n = 2'b11; oe_l_n = 1'b0;
  endtask
  task automatic idle_r();
    ce0_r_n = 1'b1; ce1_r = 1'b0; rw_r_n = 1'b1; lane_r_n = 2'b11; oe_r_n = 1'b0;
  endtask

  task automatic set_l(input bit wr, input logic [1:0] ln, input logic [11:0] a,
                       input logic [17:0] d);
    ce0_l_n = 1'b0; ce1_l = 1'b1; rw_l_n = ~wr; lane_l_n = ln; addr_l = a; wdata_l = d;
  endtask
  task automatic set_r(input bit wr, input logic [1:0] ln, input logic [11:0] a,
                       input logic [17:0] d);
    ce0_r_n = 1'b0; ce1_r = 1'b1; rw_r_n = ~wr; lane_r_n = ln; addr_r = a; wdata_r = d;
  endtask

  task automatic gap();
    repeat (2) @(negedge clk);
  endtask

  // called at a falling edge; leaves the port idle
  task automatic write_l(input logic [1:0] ln, input logic [11:0] a, input logic [17:0] d);
    set_l(1'b1, ln, a, d);
    @(negedge clk);
    check(drive_l == 2'b00, "R4 write cycle drives no lane", {16'h0, drive_l}, 18'h0);
    idle_l();
    gap();
  endtask
  task automatic write_r(input logic [1:0] ln, input logic [11:0] a, input logic [17:0] d);
    set_r(1'b1, ln, a, d);
    @(negedge clk);
    idle_r();
    gap();
  endtask

  // flow-through left read: driven one edge after capture, quiet after the next
  task automatic read_l(input logic [11:0] a, input logic [17:0] exp, input string tag);
    set_l(1'b0, 2'b00, a, 18'h0);
    @(negedge clk);
    check(drive_l == 2'b11, {tag, " drive"}, {16'h0, drive_l}, 18'h3);
    check(rdata_l == exp, tag, rdata_l, exp);
    idle_l();
    @(negedge clk);
    check(drive_l == 2'b00, "R4 flow-through quiet after deselect", {16'h0, drive_l}, 18'h0);
    @(negedge clk);
  endtask

  // pipelined right read: driven two edges after capture, quiet one edge later
  task automatic read_r(input logic [11:0] a, input logic [17:0] exp, input string tag);
    set_r(1'b0, 2'b00, a, 18'h0);
    @(negedge clk);
    idle_r();
    check(drive_r == 2'b00, "R5 pipelined output not yet driven", {16'h0, drive_r}, 18'h0);
    @(negedge clk);
    check(drive_r == 2'b11, {tag, " drive"}, {16'h0, drive_r}, 18'h3);
    check(rdata_r == exp, tag, rdata_r, exp);
    @(negedge clk);
    check(drive_r == 2'b00, "R5 pipelined quiet one edge after deselect",
          {16'h0, drive_r}, 18'h0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pipe_l = 1'b0; pipe_r = 1'b1;
    addr_l = '0; wdata_l = '0; addr_r = '0; wdata_r = '0;
    idle_l(); idle_r();
    repeat (4) @(negedge clk);
    // R10: reset state
    check(drive_l == 2'b00 && drive_r == 2'b00, "R10 no drive in reset",
          {14'h0, drive_l, drive_r}, 18'h0);
    check(clash == 1'b0, "R10 clash low in reset", {17'h0, clash}, 18'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(drive_l == 2'b00 && drive_r == 2'b00 && clash == 1'b0,
          "R10 quiet after reset", {13'h0, drive_l, drive_r, clash}, 18'h0);

    // table walk (R2, R3, R9)
    for (int i = 0; i < 8; i++) begin
      logic [51:0] v;
      v = VECS[i];
      if (v[50]) begin
        if (v[51]) write_r(v[49:48], v[47:36], v[35:18]);
        else       write_l(v[49:48], v[47:36], v[35:18]);
      end else begin
        if (v[51]) read_r(v[47:36], v[17:0], "R9 R3 cross-port read");
        else       read_l(v[47:36], v[17:0], "R2 R3 lane-merged read");
      end
    end

    // R1: writes with the enables in the wrong state change nothing
    ce0_l_n = 1'b1; ce1_l = 1'b1; rw_l_n = 1'b0; lane_l_n = 2'b00;
    addr_l = 12'h010; wdata_l = 18'h0;
    @(negedge clk);
    ce0_l_n = 1'b0; ce1_l = 1'b0;
    @(negedge clk);
    ce0_l_n = 1'b0; ce1_l = 1'b0; rw_l_n = 1'b1;
    @(negedge clk);
    check(drive_l == 2'b00, "R1 deselected read not driven", {16'h0, drive_l}, 18'h0);
    idle_l();
    gap();
    read_l(12'h010, {9'h1F0, 9'h0AA}, "R1 word unchanged by deselected writes");

    // R6: output enable gates drive without a clock; single-lane read
    set_l(1'b0, 2'b00, 12'h123, 18'h0);
    oe_l_n = 1'b1;
    @(negedge clk);
    check(drive_l == 2'b00, "R6 oe high blocks drive", {16'h0, drive_l}, 18'h0);
    oe_l_n = 1'b0;
    #2;
    check(drive_l == 2'b11, "R6 oe acts without clock", {16'h0, drive_l}, 18'h3);
    idle_l();
    gap();
    set_l(1'b0, 2'b10, 12'h123, 18'h0);
    @(negedge clk);
    check(drive_l == 2'b01, "R6 R2 only lane 0 driven", {16'h0, drive_l}, 18'h1);
    check(rdata_l[8:0] == 9'h033, "R2 lane 0 data", {9'h0, rdata_l[8:0]}, 18'h033);
    idle_l();
    gap();

    // R7: a read captured with the write sees old data; a later read sees new
    write_l(2'b00, 12'h300, {9'h001, 9'h002});
    set_l(1'b1, 2'b00, 12'h300, {9'h003, 9'h004});
    set_r(1'b0, 2'b00, 12'h300, 18'h0);
    @(negedge clk);
    idle_l(); idle_r();
    @(negedge clk);
    check(rdata_r == {9'h001, 9'h002} && drive_r == 2'b11, "R7 same-edge read old",
          rdata_r, {9'h001, 9'h002});
    gap();
    read_r(12'h300, {9'h003, 9'h004}, "R7 later read new");

    // R8: same word, same edge: left wins lane 0, right alone owns lane 1
    set_l(1'b1, 2'b10, 12'h400, {9'h1FF, 9'h022});
    set_r(1'b1, 2'b00, 12'h400, {9'h0AB, 9'h0CD});
    @(negedge clk);
    idle_l(); idle_r();
    check(clash == 1'b0, "R8 clash not early", {17'h0, clash}, 18'h0);
    @(negedge clk);
    check(clash == 1'b1, "R8 clash pulse", {17'h0, clash}, 18'h1);
    @(negedge clk);
    check(clash == 1'b0, "R8 clash one cycle", {17'h0, clash}, 18'h0);
    gap();
    read_l(12'h400, {9'h0AB, 9'h022}, "R8 per-lane precedence");
    read_r(12'h400, {9'h0AB, 9'h022}, "R8 R9 precedence seen on right");

    // R8: different words at the same edge raise no clash
    set_l(1'b1, 2'b00, 12'h500, 18'h1);
    set_r(1'b1, 2'b00, 12'h501, 18'h2);
    @(negedge clk);
    idle_l(); idle_r();
    @(negedge clk);
    check(clash == 1'b0, "R8 no clash on distinct words", {17'h0, clash}, 18'h0);
    gap();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule